// File: doc/BRIEF.md
# SDRAM Self-Refresh Entry Sequencer

This block steps an SDRAM controller down into self-refresh, a low-power mode, when software sets a configuration enable bit. It waits for the SDRAM operation that is under way to finish. It then requests a precharge-all command so that every open bank is closed, and waits a programmable precharge time. Next it requests one auto-refresh and waits a programmable refresh-cycle time. Finally it requests the self-refresh entry command, with clock-enable driven low in that same cycle. The status output rises only once the memory is actually in self-refresh.

From the moment the enable bit is accepted, the block holds an access-block output high, so the controller front end stops taking read and write requests. Clearing the enable bit while the memory is in self-refresh raises clock-enable again and waits a programmable exit delay. After that delay the status output clears and accesses are allowed again. Software is expected to drain all pending and queued requests before it sets the enable bit. The three wait counts are presented as inputs and are captured in the cycle that issues the command they follow.

Top module: `srf_entry_seq`

## Requirements
- R1: After reset the block is idle: `cke` is 1; `sr_status`, `access_block` and the three command outputs are 0.
- R2: When `sr_enable` is 1 in an idle cycle, `access_block` is 1 from the next cycle on. It stays 1 until the exit delay has run out, and is 0 whenever the block is idle. No command is issued while `op_busy` stays 1.
- R3: A single-cycle `cmd_pre_all` is issued in the cycle that follows the first cycle in which the block is draining and `op_busy` is 0.
- R4: `cmd_refresh` is issued exactly max(P,1)+1 cycles after the `cmd_pre_all` cycle. P is the value of `t_rp` during the precharge-all cycle.
- R5: `cmd_sr_enter` is issued exactly max(F,1)+1 cycles after the `cmd_refresh` cycle. F is the value of `t_rfc` during the refresh cycle. `cke` is 0 in that same cycle.
- R6: `sr_status` rises in the cycle after `cmd_sr_enter`. While the block remains in self-refresh, `cke` stays 0 and `access_block` stays 1.
- R7: At most one of `cmd_pre_all`, `cmd_refresh` and `cmd_sr_enter` is 1 in any cycle, and each lasts one cycle per sequence.
- R8: If `sr_enable` is 0 in a self-refresh cycle, `cke` is 1 from the next cycle. `sr_status` stays 1 for max(X,1) further cycles, where X is `t_xsr` during that cycle. Then `sr_status` and `access_block` both fall to 0.
- R9: Once a sequence has started, changing `sr_enable` has no effect on the entry steps, and no step repeats. If the enable is already 0 when self-refresh is reached, exit starts after a single self-refresh cycle.
- R10: A change of `t_rp` or `t_rfc` while a wait is running does not change the length of that wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sr_enable | input | 1 | Self-refresh request bit from configuration |
| op_busy | input | 1 | Current SDRAM operation still in progress |
| t_rp | input | CNT_W | Precharge wait count |
| t_rfc | input | CNT_W | Refresh-cycle wait count |
| t_xsr | input | CNT_W | Self-refresh exit delay count |
| cmd_pre_all | output | 1 | Precharge-all command request |
| cmd_refresh | output | 1 | Auto-refresh command request |
| cmd_sr_enter | output | 1 | Self-refresh entry command request |
| cke | output | 1 | SDRAM clock-enable |
| sr_status | output | 1 | Memory is in self-refresh |
| access_block | output | 1 | Reject new read and write requests |

## Verification
Two pairs of events can fall in the same cycle. In the first, the enable bit is withdrawn in the very cycle that issues the self-refresh entry command. The block must still enter self-refresh, report status, and then leave after one self-refresh cycle. In the second, `op_busy` falls in the first draining cycle, so the precharge-all command must follow with no extra wait. The bench drives both coincidences on purpose, with minimum wait counts as well as with longer ones. It judges every cycle against a behavioural model, and it measures the command spacing in cycles from the ports.

// File: rtl/srf_pkg.sv
package srf_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_PRE,
        ST_WAIT_RP,
        ST_AREF,
        ST_WAIT_RFC,
        ST_SRE,
        ST_SELF,
        ST_EXIT
    } srf_state_e;

    typedef enum logic [1:0] {
        TSEL_RP,
        TSEL_RFC,
        TSEL_XSR
    } srf_tsel_e;

    typedef struct packed {
        srf_state_e state;
    } srf_ctrl_t;

    typedef struct packed {
        logic pre_all;
        logic refresh;
        logic sr_enter;
        logic cke;
        logic status;
        logic block;
    } srf_out_t;

endpackage

// File: rtl/srf_timer.sv
module srf_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // a count of 0 or 1 both give one wait cycle
    assign expired = (cnt_q <= ONE);
endmodule

// File: rtl/srf_ctrl.sv
module srf_ctrl
    import srf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sr_enable,
    input  logic       op_busy,
    input  logic       tmr_expired,
    output srf_state_e state,
    output logic       tmr_load,
    output srf_tsel_e  tmr_sel
);
    srf_ctrl_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_sel  = TSEL_RP;
        unique case (r_q.state)
            ST_IDLE:     if (sr_enable) r_d.state = ST_DRAIN;
            ST_DRAIN:    if (!op_busy) r_d.state = ST_PRE;
            ST_PRE: begin
                tmr_load  = 1'b1;
                tmr_sel   = TSEL_RP;
                r_d.state = ST_WAIT_RP;
            end
            ST_WAIT_RP:  if (tmr_expired) r_d.state = ST_AREF;
            ST_AREF: begin
                tmr_load  = 1'b1;
                tmr_sel   = TSEL_RFC;
                r_d.state = ST_WAIT_RFC;
            end
            ST_WAIT_RFC: if (tmr_expired) r_d.state = ST_SRE;
            ST_SRE:      r_d.state = ST_SELF;
            ST_SELF: begin
                if (!sr_enable) begin
                    tmr_load  = 1'b1;
                    tmr_sel   = TSEL_XSR;
                    r_d.state = ST_EXIT;
                end
            end
            ST_EXIT:     if (tmr_expired) r_d.state = ST_IDLE;
            default:     r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE};
        else        r_q <= r_d;
    end

    assign state = r_q.state;
endmodule

// File: rtl/srf_out_decode.sv
module srf_out_decode
    import srf_pkg::*;
(
    input  srf_state_e state,
    output srf_out_t   o
);
    always_comb begin
        o         = '0;
        o.cke     = 1'b1;
        o.block   = (state != ST_IDLE);
        unique case (state)
            ST_PRE:  o.pre_all  = 1'b1;
            ST_AREF: o.refresh  = 1'b1;
            ST_SRE: begin
                o.sr_enter = 1'b1;
                o.cke      = 1'b0;
            end
            ST_SELF: begin
                o.cke    = 1'b0;
                o.status = 1'b1;
            end
            ST_EXIT: o.status = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/srf_entry_seq.sv
module srf_entry_seq
    import srf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sr_enable,
    input  logic             op_busy,
    input  logic [CNT_W-1:0] t_rp,
    input  logic [CNT_W-1:0] t_rfc,
    input  logic [CNT_W-1:0] t_xsr,
    output logic             cmd_pre_all,
    output logic             cmd_refresh,
    output logic             cmd_sr_enter,
    output logic             cke,
    output logic             sr_status,
    output logic             access_block
);
    srf_state_e       state;
    logic             tmr_load, tmr_expired;
    srf_tsel_e        tmr_sel;
    logic [CNT_W-1:0] tmr_val;
    srf_out_t         outs;

    srf_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sr_enable   (sr_enable),
        .op_busy     (op_busy),
        .tmr_expired (tmr_expired),
        .state       (state),
        .tmr_load    (tmr_load),
        .tmr_sel     (tmr_sel)
    );

    always_comb begin
        unique case (tmr_sel)
            TSEL_RFC: tmr_val = t_rfc;
            TSEL_XSR: tmr_val = t_xsr;
            default:  tmr_val = t_rp;
        endcase
    end

    srf_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    srf_out_decode u_dec (
        .state (state),
        .o     (outs)
    );

    assign cmd_pre_all  = outs.pre_all;
    assign cmd_refresh  = outs.refresh;
    assign cmd_sr_enter = outs.sr_enter;
    assign cke          = outs.cke;
    assign sr_status    = outs.status;
    assign access_block = outs.block;
endmodule

// File: rtl/srf_entry_seq_chk.sv
module srf_entry_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic op_busy,
    input logic cmd_pre_all,
    input logic cmd_refresh,
    input logic cmd_sr_enter,
    input logic cke,
    input logic sr_status,
    input logic access_block
);
    assert_one_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_pre_all, cmd_refresh, cmd_sr_enter}));

    assert_pre_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pre_all |=> !cmd_pre_all && !cmd_refresh);

    assert_pre_after_idle_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pre_all |-> !$past(op_busy));

    assert_sre_cke_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sr_enter |=> sr_status && !cke);

    assert_status_from_sre_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_status) |-> $past(cmd_sr_enter));

    assert_status_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sr_status |-> access_block);

    assert_exit_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_status) |-> cke && !access_block);
endmodule

bind srf_entry_seq srf_entry_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_busy      (op_busy),
    .cmd_pre_all  (cmd_pre_all),
    .cmd_refresh  (cmd_refresh),
    .cmd_sr_enter (cmd_sr_enter),
    .cke          (cke),
    .sr_status    (sr_status),
    .access_block (access_block)
);

// File: tb/srf_entry_seq_test.sv
module srf_entry_seq_test;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sr_enable = 1'b0;
    logic op_busy = 1'b0;
    logic [W-1:0] t_rp = 8'd3, t_rfc = 8'd5, t_xsr = 8'd4;
    logic cmd_pre_all, cmd_refresh, cmd_sr_enter, cke, sr_status, access_block;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    // model: 0 idle 1 drain 2 pre 3 wait 4 ref 5 wait 6 enter 7 self 8 exit
    int mph = 0, mcnt = 0;
    int pre_cyc = -100, ref_cyc = -100, rp_used = 0, rfc_used = 0;
    int pre_cnt = 0, ref_cnt = 0, sre_cnt = 0;
    bit last_pre = 0, last_ref = 0;

    always #2 clk = ~clk;

    srf_entry_seq #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .sr_enable(sr_enable), .op_busy(op_busy),
        .t_rp(t_rp), .t_rfc(t_rfc), .t_xsr(t_xsr),
        .cmd_pre_all(cmd_pre_all), .cmd_refresh(cmd_refresh),
        .cmd_sr_enter(cmd_sr_enter), .cke(cke), .sr_status(sr_status),
        .access_block(access_block)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int atleast1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic model_step();
        case (mph)
            0: if (sr_enable) mph = 1;
            1: if (!op_busy) mph = 2;
            2: begin mcnt = int'(t_rp); mph = 3; end
            3: if (mcnt <= 1) mph = 4; else mcnt--;
            4: begin mcnt = int'(t_rfc); mph = 5; end
            5: if (mcnt <= 1) mph = 6; else mcnt--;
            6: mph = 7;
            7: if (!sr_enable) begin mcnt = int'(t_xsr); mph = 8; end
            8: if (mcnt <= 1) mph = 0; else mcnt--;
            default: mph = 0;
        endcase
    endtask

    task automatic tick();
        if (last_pre) rp_used = int'(t_rp);
        if (last_ref) rfc_used = int'(t_rfc);
        @(posedge clk);
        if (rst_n) model_step();
        #1;
        cyc++;
        chk(cmd_pre_all == (mph == 2), "R3", "cmd_pre_all", cmd_pre_all, mph == 2);
        chk(cmd_refresh == (mph == 4), "R4", "cmd_refresh", cmd_refresh, mph == 4);
        chk(cmd_sr_enter == (mph == 6), "R5", "cmd_sr_enter", cmd_sr_enter, mph == 6);
        chk(cke == !(mph == 6 || mph == 7), "R8", "cke", cke, !(mph == 6 || mph == 7));
        chk(sr_status == (mph == 7 || mph == 8), "R6", "sr_status", sr_status,
            mph == 7 || mph == 8);
        chk(access_block == (mph != 0), "R2", "access_block", access_block, mph != 0);
        chk((int'(cmd_pre_all) + int'(cmd_refresh) + int'(cmd_sr_enter)) <= 1, "R7",
            "command count", int'(cmd_pre_all) + int'(cmd_refresh) + int'(cmd_sr_enter), 1);
        if (cmd_pre_all) begin pre_cyc = cyc; pre_cnt++; end
        if (cmd_refresh) begin
            ref_cyc = cyc; ref_cnt++;
            chk(cyc - pre_cyc == atleast1(rp_used) + 1, "R4", "pre-to-refresh gap",
                cyc - pre_cyc, atleast1(rp_used) + 1);
        end
        if (cmd_sr_enter) begin
            sre_cnt++;
            chk(cyc - ref_cyc == atleast1(rfc_used) + 1, "R5", "refresh-to-enter gap",
                cyc - ref_cyc, atleast1(rfc_used) + 1);
        end
        last_pre = cmd_pre_all;
        last_ref = cmd_refresh;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && access_block; i++) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        run(3);
        // R1: reset state
        chk(cke && !sr_status && !access_block && !cmd_pre_all && !cmd_refresh &&
            !cmd_sr_enter, "R1", "reset outputs", {cke, sr_status, access_block}, 3'b100);
        rst_n = 1'b1;
        run(2);

        // Scenario A: busy drains over several cycles, normal counts
        op_busy = 1'b1; sr_enable = 1'b1;
        run(5);
        chk(pre_cnt == 0, "R2", "no command while busy", pre_cnt, 0);
        op_busy = 1'b0;
        run(30);
        chk(sr_status && !cke, "R6", "in self-refresh", sr_status, 1);
        sr_enable = 1'b0;
        wait_idle();
        run(3);
        chk(!access_block && cke && !sr_status, "R8", "released after exit",
            access_block, 0);

        // Scenario B: minimum counts, busy low when enabled
        t_rp = 0; t_rfc = 1; t_xsr = 0;
        pre_cnt = 0; ref_cnt = 0; sre_cnt = 0;
        sr_enable = 1'b1;
        run(12);
        chk(sre_cnt == 1 && sr_status, "R6", "entered with minimum counts", sre_cnt, 1);
        sr_enable = 1'b0;
        wait_idle();

        // Scenario C: enable toggles mid-sequence, counts change mid-wait,
        // enable withdrawn in the entry-command cycle
        t_rp = 6; t_rfc = 7; t_xsr = 5;
        pre_cnt = 0; ref_cnt = 0; sre_cnt = 0;
        op_busy = 1'b1; sr_enable = 1'b1;
        tick();
        op_busy = 1'b0;  // falls in first draining cycle
        for (int i = 0; i < 100 && !cmd_pre_all; i++) tick();
        tick();
        t_rp = 1;        // R10: wait already loaded
        sr_enable = 1'b0;
        run(2);
        sr_enable = 1'b1;
        for (int i = 0; i < 100 && !cmd_refresh; i++) tick();
        tick();
        t_rfc = 30;      // R10
        for (int i = 0; i < 100 && !cmd_sr_enter; i++) tick();
        sr_enable = 1'b0;
        tick();
        chk(sr_status, "R9", "self-refresh reached despite withdrawal", sr_status, 1);
        tick();
        chk(cke && sr_status, "R9", "exit after one self-refresh cycle", cke, 1);
        wait_idle();
        chk(pre_cnt == 1 && ref_cnt == 1 && sre_cnt == 1, "R9", "no repeated step",
            pre_cnt + ref_cnt + sre_cnt, 3);

        // Scenario D: enable set again during exit restarts only after idle
        t_rp = 2; t_rfc = 2; t_xsr = 6;
        sr_enable = 1'b1;
        run(20);
        sr_enable = 1'b0;
        run(2);
        sr_enable = 1'b1;
        run(30);
        chk(sr_status, "R2", "re-entered after idle", sr_status, 1);
        sr_enable = 1'b0;
        wait_idle();
        run(2);
        finish_run();
    end
endmodule